// File: doc/BRIEF.md
# Replicated Neighbour-Read Grid Memory

This block is the local operand store for a line-relaxation engine that works on a cubic grid of 32-bit words. It holds eight coefficient arrays and one solution array. In a single clock it returns the eight coefficients at a centre point. In the same clock it returns the four solution values next to that point along the i and k axes, so the forward datapath can take a new point every cycle without stalling.

The solution array is stored as five identical replicas. Each replica has its own read port. Four replicas serve the four neighbour reads. The fifth serves the backward unit, which reads at an address of its own. Each write to the solution array, from the backward unit or from the host, goes to all five replicas in the same cycle, so the replicas never differ.

A single signal, `engine_busy`, decides who owns the memory. While it is high, the engine ports are live and the host port is ignored. While it is low, the host loads and unloads the arrays and the engine ports are ignored. Host reads of the solution array are served from replica 0.

Top module: `grid_nbr_mem`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fwd_vld`, `nb_ok`, `bwd_rd_vld` and `host_rvld` are all 0.
- R2: A grid point (i,j,k) has linear address `{k,j,i}`, three IDX_W-bit fields with i in the low bits. `host_sel` selects the array: values 0..NCOEF-1 pick a coefficient array, 8 picks the solution array, and any other value writes nothing and reads zero. A host read returns its data with `host_rvld` one clock after the request.
- R3: While `engine_busy` is high, a host request is ignored. A read raises no `host_rvld`, and a write leaves every array unchanged.
- R4: A forward request (`fwd_en` while busy) raises `fwd_vld` one clock later. In that cycle, coefficient array c appears at `fwd_coef[32c+31:32c]`, read at the centre point.
- R5: In the same cycle as R4, `nb_data` slot 0 carries (i+1,j,k), slot 1 carries (i-1,j,k), slot 2 carries (i,j,k+1) and slot 3 carries (i,j,k-1). Slot n occupies bits [32n+31:32n], and `nb_ok[n]` flags it.
- R6: A neighbour whose moved index falls outside 0..2^IDX_W-1 has `nb_ok` low and its data slot reads zero.
- R7: A backward read (`bwd_rd_en` while busy) returns the solution word at its own address on `bwd_rd_data`, with `bwd_rd_vld` one clock later. This read works in the same cycle as any forward read.
- R8: A backward write while busy updates the solution array. The new value is returned by every neighbour slot, by the backward read and by host readback.
- R9: While `engine_busy` is low, forward requests, backward reads and backward writes are ignored. No valid is raised and no array changes.
- R10: A host write to the solution array reaches all five replicas. The value is returned by every neighbour slot and by the backward read.
- R11: A forward request and a backward read can be issued every clock, back to back, and each one returns its data one clock after it was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| engine_busy | input | 1 | 1: engine owns the memory; 0: host owns it |
| fwd_en | input | 1 | Forward read request |
| fwd_i | input | IDX_W | Forward centre index i |
| fwd_j | input | IDX_W | Forward centre index j |
| fwd_k | input | IDX_W | Forward centre index k |
| fwd_vld | output | 1 | Forward data valid |
| fwd_coef | output | NCOEF*32 | Centre coefficients, array c in slot c |
| nb_data | output | 4*32 | Neighbour solution values, order i+1, i-1, k+1, k-1 |
| nb_ok | output | 4 | Per-neighbour in-range flag |
| bwd_rd_en | input | 1 | Backward read request |
| bwd_rd_i | input | IDX_W | Backward read index i |
| bwd_rd_j | input | IDX_W | Backward read index j |
| bwd_rd_k | input | IDX_W | Backward read index k |
| bwd_rd_vld | output | 1 | Backward read valid |
| bwd_rd_data | output | 32 | Backward read data |
| bwd_wr_en | input | 1 | Backward result write |
| bwd_wr_i | input | IDX_W | Write index i |
| bwd_wr_j | input | IDX_W | Write index j |
| bwd_wr_k | input | IDX_W | Write index k |
| bwd_wr_data | input | 32 | Result word |
| host_en | input | 1 | Host request |
| host_we | input | 1 | Host request is a write |
| host_sel | input | 4 | Array select (0..7 coefficient, 8 solution) |
| host_addr | input | 3*IDX_W | Linear address `{k,j,i}` |
| host_wdata | input | 32 | Host write data |
| host_rvld | output | 1 | Host read valid |
| host_rdata | output | 32 | Host read data |

## Verification
The assertions take for granted that `engine_busy` only changes between complete requests. They also take for granted that the bench looks at outputs only in the cycle after a request, because the data ports carry stale RAM contents in every other cycle. The replica cross-check further assumes that a read issued in the same cycle as a write to the same address returns the old word, and that all replicas behave this way. The bench keeps within these assumptions: it changes ownership only through directed phases, it samples valid and data together one clock after each request, and its model computes each expected value before it applies that cycle's write. Random backward reads are sometimes steered onto the forward i+1 neighbour, so that the replica-equality property is actually exercised.

// File: rtl/gridmem_pkg.sv
package gridmem_pkg;
    localparam int SEL_W   = 4;
    localparam int NB_CNT  = 4;
    localparam int REP_CNT = 5;
    // neighbour slot numbering, relied on by the forward datapath
    localparam int NB_IP = 0;
    localparam int NB_IM = 1;
    localparam int NB_KP = 2;
    localparam int NB_KM = 3;
    localparam logic [SEL_W-1:0] SEL_SOLN = 4'd8;

    typedef struct packed {
        logic              fwd_vld;
        logic [NB_CNT-1:0] nb_ok;
        logic              bwd_vld;
        logic              host_vld;
        logic [SEL_W-1:0]  host_sel;
    } rd_ctl_t;
endpackage

// File: rtl/grid_nbr_addr.sv
module grid_nbr_addr
    import gridmem_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [IDX_W-1:0]        idx_j,
    input  logic [IDX_W-1:0]        idx_k,
    output logic [3*IDX_W-1:0]      ctr_addr,
    output logic [NB_CNT*3*IDX_W-1:0] nb_addr,
    output logic [NB_CNT-1:0]       nb_ok
);
    localparam int AW = 3 * IDX_W;

    assign ctr_addr = {idx_k, idx_j, idx_i};

    for (genvar n = 0; n < NB_CNT; n++) begin : g_nb
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] moved;
        if (n == NB_IP || n == NB_IM) begin : g_axis_i
            assign src = idx_i;
            assign nb_addr[n*AW +: AW] = {idx_k, idx_j, moved};
        end else begin : g_axis_k
            assign src = idx_k;
            assign nb_addr[n*AW +: AW] = {moved, idx_j, idx_i};
        end
        if (n == NB_IP || n == NB_KP) begin : g_up
            assign moved = src + IDX_W'(1);
            assign nb_ok[n] = (src != {IDX_W{1'b1}});
        end else begin : g_dn
            assign moved = src - IDX_W'(1);
            assign nb_ok[n] = (src != {IDX_W{1'b0}});
        end
    end
endmodule

// File: rtl/grid_ram.sv
module grid_ram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem_q[raddr];
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/grid_nbr_mem.sv
module grid_nbr_mem
    import gridmem_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int DW    = 32,
    parameter int NCOEF = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  engine_busy,
    input  logic                  fwd_en,
    input  logic [IDX_W-1:0]      fwd_i,
    input  logic [IDX_W-1:0]      fwd_j,
    input  logic [IDX_W-1:0]      fwd_k,
    output logic                  fwd_vld,
    output logic [NCOEF*DW-1:0]   fwd_coef,
    output logic [4*DW-1:0]       nb_data,
    output logic [3:0]            nb_ok,
    input  logic                  bwd_rd_en,
    input  logic [IDX_W-1:0]      bwd_rd_i,
    input  logic [IDX_W-1:0]      bwd_rd_j,
    input  logic [IDX_W-1:0]      bwd_rd_k,
    output logic                  bwd_rd_vld,
    output logic [DW-1:0]         bwd_rd_data,
    input  logic                  bwd_wr_en,
    input  logic [IDX_W-1:0]      bwd_wr_i,
    input  logic [IDX_W-1:0]      bwd_wr_j,
    input  logic [IDX_W-1:0]      bwd_wr_k,
    input  logic [DW-1:0]         bwd_wr_data,
    input  logic                  host_en,
    input  logic                  host_we,
    input  logic [3:0]            host_sel,
    input  logic [3*IDX_W-1:0]    host_addr,
    input  logic [DW-1:0]         host_wdata,
    output logic                  host_rvld,
    output logic [DW-1:0]         host_rdata
);
    localparam int AW = 3 * IDX_W;

    rd_ctl_t ctl_d, ctl_q;

    logic [AW-1:0]        ctr_addr;
    logic [NB_CNT*AW-1:0] nb_addr;
    logic [NB_CNT-1:0]    nb_ok_c;
    logic [NCOEF*DW-1:0]  coef_rd;
    logic [REP_CNT*DW-1:0] rep_rd;

    logic          host_wr, host_rd;
    logic          rep_we;
    logic [AW-1:0] rep_waddr;
    logic [DW-1:0] rep_wdata;
    logic [AW-1:0] bwd_raddr;

    grid_nbr_addr #(.IDX_W(IDX_W)) u_addr (
        .idx_i    (fwd_i),
        .idx_j    (fwd_j),
        .idx_k    (fwd_k),
        .ctr_addr (ctr_addr),
        .nb_addr  (nb_addr),
        .nb_ok    (nb_ok_c)
    );

    // ownership split between host and engine
    always_comb begin
        host_wr   = !engine_busy && host_en && host_we;
        host_rd   = !engine_busy && host_en && !host_we;
        bwd_raddr = {bwd_rd_k, bwd_rd_j, bwd_rd_i};
        if (engine_busy) begin
            rep_we    = bwd_wr_en;
            rep_waddr = {bwd_wr_k, bwd_wr_j, bwd_wr_i};
            rep_wdata = bwd_wr_data;
        end else begin
            rep_we    = host_wr && (host_sel == SEL_SOLN);
            rep_waddr = host_addr;
            rep_wdata = host_wdata;
        end
    end

    // coefficient arrays: one shared read address
    for (genvar c = 0; c < NCOEF; c++) begin : g_coef
        logic          c_we;
        logic [AW-1:0] c_raddr;
        assign c_we    = host_wr && (host_sel == SEL_W'(c));
        assign c_raddr = engine_busy ? ctr_addr : host_addr;
        grid_ram #(.AW(AW), .DW(DW)) u_ram (
            .clk   (clk),
            .we    (c_we),
            .waddr (host_addr),
            .wdata (host_wdata),
            .raddr (c_raddr),
            .rdata (coef_rd[c*DW +: DW])
        );
    end

    // solution replicas: common write, private read address
    for (genvar r = 0; r < REP_CNT; r++) begin : g_rep
        logic [AW-1:0] r_raddr;
        if (r == 0) begin : g_r0
            assign r_raddr = engine_busy ? nb_addr[0 +: AW] : host_addr;
        end else if (r < NB_CNT) begin : g_rn
            assign r_raddr = nb_addr[r*AW +: AW];
        end else begin : g_rb
            assign r_raddr = bwd_raddr;
        end
        grid_ram #(.AW(AW), .DW(DW)) u_ram (
            .clk   (clk),
            .we    (rep_we),
            .waddr (rep_waddr),
            .wdata (rep_wdata),
            .raddr (r_raddr),
            .rdata (rep_rd[r*DW +: DW])
        );
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.fwd_vld  = engine_busy && fwd_en;
        ctl_d.nb_ok    = (engine_busy && fwd_en) ? nb_ok_c : '0;
        ctl_d.bwd_vld  = engine_busy && bwd_rd_en;
        ctl_d.host_vld = host_rd;
        ctl_d.host_sel = host_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        host_rdata = '0;
        if (ctl_q.host_sel == SEL_SOLN) begin
            host_rdata = rep_rd[0 +: DW];
        end
        for (int c = 0; c < NCOEF; c++) begin
            if (ctl_q.host_sel == SEL_W'(c)) begin
                host_rdata = coef_rd[c*DW +: DW];
            end
        end
    end

    for (genvar n = 0; n < NB_CNT; n++) begin : g_nbout
        assign nb_data[n*DW +: DW] = ctl_q.nb_ok[n] ? rep_rd[n*DW +: DW] : '0;
    end

    assign fwd_vld     = ctl_q.fwd_vld;
    assign fwd_coef    = coef_rd;
    assign nb_ok       = ctl_q.nb_ok;
    assign bwd_rd_vld  = ctl_q.bwd_vld;
    assign bwd_rd_data = rep_rd[NB_CNT*DW +: DW];
    assign host_rvld   = ctl_q.host_vld;

    AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> !host_rvld); // R3
    AST_FWD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && fwd_en) |=> fwd_vld); // R4
    AST_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && fwd_en && fwd_i == '0) |=> (!nb_ok[NB_IM] && nb_data[NB_IM*DW +: DW] == '0)); // R6
    AST_BWD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && bwd_rd_en) |=> bwd_rd_vld); // R7
    AST_REPL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (engine_busy && fwd_en && bwd_rd_en && fwd_i != {IDX_W{1'b1}} &&
         bwd_raddr == {fwd_k, fwd_j, fwd_i + IDX_W'(1)})
        |=> (bwd_rd_data == nb_data[0 +: DW])); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !engine_busy |=> (!fwd_vld && !bwd_rd_vld && nb_ok == '0)); // R9
endmodule

// File: tb/tb_grid_nbr_mem.sv
`timescale 1ns/1ps
module tb_grid_nbr_mem;
    localparam int IDX_W = 3;
    localparam int DW    = 32;
    localparam int NC    = 8;
    localparam int AW    = 3 * IDX_W;
    localparam int DEPTH = 1 << AW;
    localparam int MAXI  = (1 << IDX_W) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic engine_busy = 0;
    logic fwd_en = 0;
    logic [IDX_W-1:0] fwd_i = 0, fwd_j = 0, fwd_k = 0;
    logic fwd_vld;
    logic [NC*DW-1:0] fwd_coef;
    logic [4*DW-1:0] nb_data;
    logic [3:0] nb_ok;
    logic bwd_rd_en = 0;
    logic [IDX_W-1:0] bwd_rd_i = 0, bwd_rd_j = 0, bwd_rd_k = 0;
    logic bwd_rd_vld;
    logic [DW-1:0] bwd_rd_data;
    logic bwd_wr_en = 0;
    logic [IDX_W-1:0] bwd_wr_i = 0, bwd_wr_j = 0, bwd_wr_k = 0;
    logic [DW-1:0] bwd_wr_data = 0;
    logic host_en = 0, host_we = 0;
    logic [3:0] host_sel = 0;
    logic [AW-1:0] host_addr = 0;
    logic [DW-1:0] host_wdata = 0;
    logic host_rvld;
    logic [DW-1:0] host_rdata;

    always #4 clk = ~clk;

    grid_nbr_mem #(.IDX_W(IDX_W), .DW(DW), .NCOEF(NC)) dut (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 0;

    logic [DW-1:0] coef_m [NC][DEPTH];
    logic [DW-1:0] sol_m [DEPTH];

    function automatic int lin(int i, int j, int k);
        return (k << (2*IDX_W)) | (j << IDX_W) | i;
    endfunction

    task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compute expectations from inputs and model, update model, check next cycle
    task automatic tick();
        bit e_fv, e_bv, e_hv;
        logic [DW-1:0] e_coef [NC];
        logic [DW-1:0] e_nb [4];
        bit e_ok [4];
        logic [DW-1:0] e_bwd, e_host;
        int ci, ck, ca;
        e_fv = engine_busy && fwd_en;
        e_bv = engine_busy && bwd_rd_en;
        e_hv = !engine_busy && host_en && !host_we;
        ci = int'(fwd_i); ck = int'(fwd_k);
        ca = lin(ci, int'(fwd_j), ck);
        for (int c = 0; c < NC; c++) e_coef[c] = coef_m[c][ca];
        for (int n = 0; n < 4; n++) begin
            int ni, nk;
            ni = ci + ((n == 0) ? 1 : (n == 1) ? -1 : 0);
            nk = ck + ((n == 2) ? 1 : (n == 3) ? -1 : 0);
            e_ok[n] = e_fv && ni >= 0 && ni <= MAXI && nk >= 0 && nk <= MAXI;
            e_nb[n] = e_ok[n] ? sol_m[lin(ni, int'(fwd_j), nk)] : '0;
        end
        e_bwd = sol_m[lin(int'(bwd_rd_i), int'(bwd_rd_j), int'(bwd_rd_k))];
        if (host_sel < 4'd8) e_host = coef_m[host_sel][host_addr];
        else if (host_sel == 4'd8) e_host = sol_m[host_addr];
        else e_host = '0;
        if (engine_busy && bwd_wr_en)
            sol_m[lin(int'(bwd_wr_i), int'(bwd_wr_j), int'(bwd_wr_k))] = bwd_wr_data;
        if (!engine_busy && host_en && host_we) begin
            if (host_sel < 4'd8) coef_m[host_sel][host_addr] = host_wdata;
            else if (host_sel == 4'd8) sol_m[host_addr] = host_wdata;
        end
        @(negedge clk);
        chk(fwd_vld == e_fv, engine_busy ? "R4 fwd_vld" : "R9 fwd_vld idle", 32'(fwd_vld), 32'(e_fv));
        chk(bwd_rd_vld == e_bv, engine_busy ? "R7 bwd_vld" : "R9 bwd_vld idle", 32'(bwd_rd_vld), 32'(e_bv));
        chk(host_rvld == e_hv, engine_busy ? "R3 host_rvld busy" : "R2 host_rvld", 32'(host_rvld), 32'(e_hv));
        if (e_fv) begin
            for (int c = 0; c < NC; c++)
                chk(fwd_coef[c*DW +: DW] == e_coef[c], "R4 R11 coef", fwd_coef[c*DW +: DW], e_coef[c]);
            for (int n = 0; n < 4; n++) begin
                chk(nb_ok[n] == e_ok[n], "R6 nb_ok", 32'(nb_ok[n]), 32'(e_ok[n]));
                chk(nb_data[n*DW +: DW] == e_nb[n], "R5 R8 R10 nb_data", nb_data[n*DW +: DW], e_nb[n]);
            end
        end
        if (e_bv) chk(bwd_rd_data == e_bwd, "R7 R8 R10 bwd_data", bwd_rd_data, e_bwd);
        if (e_hv) chk(host_rdata == e_host, "R2 R8 host_rdata", host_rdata, e_host);
    endtask

    task automatic idle_all();
        fwd_en = 0; bwd_rd_en = 0; bwd_wr_en = 0; host_en = 0; host_we = 0;
    endtask

    task automatic host_op(bit we, int sel, int addr, logic [DW-1:0] d);
        host_en = 1; host_we = we; host_sel = 4'(sel); host_addr = AW'(addr); host_wdata = d;
        tick();
        host_en = 0; host_we = 0;
    endtask

    task automatic fwd_at(int i, int j, int k);
        fwd_en = 1; fwd_i = IDX_W'(i); fwd_j = IDX_W'(j); fwd_k = IDX_W'(k);
        tick();
        fwd_en = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!fwd_vld && !bwd_rd_vld && !host_rvld && nb_ok == 0, "R1 reset", 32'(nb_ok), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!fwd_vld && !bwd_rd_vld && !host_rvld && nb_ok == 0, "R1 after reset", 32'(nb_ok), 0);

        // R2 R10: host load of all arrays
        for (int a = 0; a < DEPTH; a++) begin
            for (int s = 0; s <= 8; s++) host_op(1, s, a, $urandom);
        end
        // R2: select codes 9..15 write nothing, read zero
        host_op(1, 9, 5, 32'hDEAD_BEEF);
        host_op(0, 9, 5, 0);
        for (int t = 0; t < 200; t++) host_op(0, int'($urandom_range(0, 8)), int'($urandom_range(0, DEPTH-1)), 0);

        // R9: engine ports ignored while idle
        fwd_en = 1; bwd_rd_en = 1; bwd_wr_en = 1;
        bwd_wr_i = 1; bwd_wr_j = 2; bwd_wr_k = 3; bwd_wr_data = 32'hA5A5_0001;
        tick();
        idle_all();
        host_op(0, 8, lin(1, 2, 3), 0);

        // R3: host ignored while busy
        engine_busy = 1;
        host_op(1, 8, lin(4, 4, 4), 32'h1234_5678);
        host_op(1, 0, lin(4, 4, 4), 32'h1234_5678);
        host_op(0, 8, lin(4, 4, 4), 0);
        engine_busy = 0;
        host_op(0, 8, lin(4, 4, 4), 0);
        host_op(0, 0, lin(4, 4, 4), 0);

        // R5 R6: grid corners and edges
        engine_busy = 1;
        fwd_at(0, 0, 0);
        fwd_at(MAXI, 3, MAXI);
        fwd_at(0, 5, MAXI);
        fwd_at(MAXI, 1, 0);
        fwd_at(3, 3, 3);

        // R8: backward write then neighbours/backward read see it
        bwd_wr_en = 1; bwd_wr_i = 5; bwd_wr_j = 2; bwd_wr_k = 4; bwd_wr_data = 32'hCAFE_F00D;
        tick();
        bwd_wr_en = 0;
        fwd_at(4, 2, 4);
        fwd_at(6, 2, 4);
        fwd_at(5, 2, 3);
        fwd_at(5, 2, 5);

        // R11: back-to-back random forward and backward traffic
        for (int t = 0; t < 3000; t++) begin
            fwd_en = ($urandom_range(0, 9) != 0);
            fwd_i = IDX_W'($urandom); fwd_j = IDX_W'($urandom); fwd_k = IDX_W'($urandom);
            bwd_rd_en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 3) == 0) begin
                bwd_rd_i = fwd_i + IDX_W'(1); bwd_rd_j = fwd_j; bwd_rd_k = fwd_k;
            end else begin
                bwd_rd_i = IDX_W'($urandom); bwd_rd_j = IDX_W'($urandom); bwd_rd_k = IDX_W'($urandom);
            end
            bwd_wr_en = ($urandom_range(0, 2) == 0);
            bwd_wr_i = IDX_W'($urandom); bwd_wr_j = IDX_W'($urandom); bwd_wr_k = IDX_W'($urandom);
            bwd_wr_data = $urandom;
            tick();
        end
        idle_all();
        tick();

        // R8: host readback of solution from replica 0 after engine writes
        engine_busy = 0;
        for (int a = 0; a < DEPTH; a++) host_op(0, 8, a, 0);

        // R10: host write to solution seen by neighbour ports and backward read
        host_op(1, 8, lin(2, 6, 2), 32'h0BAD_C0DE);
        engine_busy = 1;
        fwd_at(1, 6, 2);
        fwd_at(3, 6, 2);
        fwd_at(2, 6, 1);
        fwd_at(2, 6, 3);
        bwd_rd_en = 1; bwd_rd_i = 2; bwd_rd_j = 6; bwd_rd_k = 2;
        tick();
        idle_all();
        engine_busy = 0;
        tick();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule